// File: doc/BRIEF.md
# Section Parity and Frame Scrambler Unit

This unit sits on one 51.84 Mb/s line stream that has been widened to 8-bit bytes (one byte per 6.48 MHz byte-clock period). It has one receive lane and one transmit lane. In the receive lane it removes the frame-synchronous scrambling and checks the section parity byte. It counts every detected parity-bit error into a saturating counter that software reads. In the transmit lane it writes the section parity byte into each frame and then scrambles the frame. Each lane is a byte stream with a start-of-frame flag on the first byte of every frame.

A single mode input selects how the unit behaves. In scrambled mode the unit works as a stand-alone single-channel line terminal: it computes and checks real BIP-8 parity. In transparent mode the unit acts as one tributary of a higher-order multiplex. It applies no scrambling. The received parity byte carries error indications that are counted directly. The transmitted parity byte is the programmed mask, sent unchanged.

Each lane has one register stage with valid/ready handshakes. A byte moves when `valid` and `ready` are both high on a clock edge. `*_in_ready` is high whenever the lane's output register is empty or is being drained in the same cycle. A held output byte stays stable until it is taken. Upstream may hold `valid` low for any number of cycles, and downstream may hold `ready` low for any number of cycles. The frame position advances only on accepted bytes.

Top module: `line_b1_scr`

## Requirements
- R1: Each lane passes its bytes in order. The output appears one cycle after the byte is accepted. While `*_out_valid` is high and `*_out_ready` is low, the output byte and its flag hold steady. An accepted byte always appears at the output in the next cycle.
- R2: A frame is ROWS×COLS = 810 accepted bytes (9 rows of 90). A byte with `*_in_sof` high is position 0, and the flag is passed through with the byte. Position 809 wraps to 0. The parity byte sits at position COLS = 90, the first byte of the second row.
- R3: In scrambled mode (`scr_mode` = 1), positions 0–2 pass unmodified. Every later byte is XORed with a keystream. The keystream comes from the generator 1 + x^6 + x^7, restarted to all ones at position 3, MSB first. The first keystream byte is 0xFE. The receive lane descrambles and the transmit lane scrambles.
- R4: In transparent mode (`scr_mode` = 0), no keystream is applied in either lane. Receive bytes pass unchanged. Transmit bytes pass unchanged except at position 90.
- R5: The frame parity is the even BIP-8 over all 810 line-side (scrambled-form) bytes of a frame. It is captured at position 809 and used during the following frame.
- R6: In scrambled mode, the unit descrambles the received byte at position 90 and XORs it with the previous frame's parity. The number of ones in the result is added to the error counter. No count is made in the first frame after reset.
- R7: In transparent mode, the number of ones in the raw received byte at position 90 is added to the error counter. Received bytes at any other position leave the counter unchanged.
- R8: In scrambled mode, the transmitted position-90 byte is the previous frame's transmit parity XORed with `tx_b1_mask`, then scrambled. Before the first complete frame after reset, the parity term is 0.
- R9: In transparent mode, the transmitted position-90 byte equals `tx_b1_mask`, whatever the input byte was.
- R10: `b1_err_count` is CNT_W bits wide (default 16). It saturates at all ones and never wraps.
- R11: A one-cycle `b1_err_rd` pulse clears the counter. If an increment lands in the same cycle, that increment is kept as the new value.
- R12: After reset the counter is 0, both output valids are low and both input readies are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scr_mode | input | 1 | 1 = scrambled single-channel mode, 0 = transparent mode |
| tx_b1_mask | input | 8 | Transmit parity error mask |
| b1_err_rd | input | 1 | Read strobe that clears the error counter |
| b1_err_count | output | CNT_W | Receive parity error count |
| rx_in_valid | input | 1 | Receive line byte valid |
| rx_in_ready | output | 1 | Receive lane can accept |
| rx_in_data | input | 8 | Receive line byte |
| rx_in_sof | input | 1 | Receive byte is frame position 0 |
| rx_out_valid | output | 1 | Descrambled byte valid |
| rx_out_ready | input | 1 | Consumer takes the descrambled byte |
| rx_out_data | output | 8 | Descrambled byte |
| rx_out_sof | output | 1 | Start-of-frame flag with the descrambled byte |
| tx_in_valid | input | 1 | Transmit payload byte valid |
| tx_in_ready | output | 1 | Transmit lane can accept |
| tx_in_data | input | 8 | Transmit byte before parity insertion |
| tx_in_sof | input | 1 | Transmit byte is frame position 0 |
| tx_out_valid | output | 1 | Line byte valid |
| tx_out_ready | input | 1 | Line side takes the byte |
| tx_out_data | output | 8 | Scrambled line byte with the parity byte inserted |
| tx_out_sof | output | 1 | Start-of-frame flag with the line byte |

## Verification
Each mode is run over several back-to-back frames, with random byte content and random stalls on both handshakes of both lanes. A wrong keystream phase, a frame count that slips under back-pressure, or parity taken on the wrong form of the data all show up as byte mismatches.

The receive parity byte is built to carry zero, one, a random number, or all eight error bits. The first frame after reset is left uncounted. This separates a bitwise-compare count from a simple flag and from a count taken with a stale or missing parity.

Two runs check different masks, which shows whether the mask is XORed with the parity or replaces it. Directed runs drive the counter into saturation with a narrow counter width, and place a read strobe exactly on an incoming parity byte.

// File: rtl/lb1_pkg.sv
package lb1_pkg;

  // Advance the 1 + x^6 + x^7 generator by eight bits, MSB first.
  // Returns {next_state, keystream_byte}.
  function automatic logic [14:0] scr_step8(input logic [6:0] s_in);
    logic [6:0] s;
    logic [7:0] ks;
    s  = s_in;
    ks = '0;
    for (int i = 7; i >= 0; i--) begin
      ks[i] = s[6];
      s     = {s[5:0], s[6] ^ s[5]};
    end
    return {s, ks};
  endfunction

  function automatic logic [3:0] ones8(input logic [7:0] v);
    logic [3:0] n;
    n = '0;
    for (int i = 0; i < 8; i++) n = n + {3'b000, v[i]};
    return n;
  endfunction

endpackage

// File: rtl/lb1_frame_scr.sv
module lb1_frame_scr #(
  parameter int ROWS     = 9,
  parameter int COLS     = 90,
  parameter int OH_UNSCR = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fire,
  input  logic       sof,
  output logic       is_first,
  output logic       is_last,
  output logic       is_b1,
  output logic       scr_on,
  output logic [7:0] ks
);
  import lb1_pkg::*;

  localparam int FRAME_LEN = ROWS * COLS;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);
  localparam logic [IDX_W-1:0] B1_IDX   = IDX_W'(COLS);
  localparam logic [IDX_W-1:0] SEED_IDX = IDX_W'(OH_UNSCR);

  logic [IDX_W-1:0] idx_q, cur_idx;
  logic [6:0]       st_q, st_cur;
  logic [14:0]      step;

  assign cur_idx  = sof ? '0 : idx_q;
  assign is_first = (cur_idx == '0);
  assign is_last  = (cur_idx == LAST_IDX);
  assign is_b1    = (cur_idx == B1_IDX);
  assign scr_on   = (cur_idx >= SEED_IDX);

  assign st_cur = (cur_idx == SEED_IDX) ? 7'h7F : st_q;
  assign step   = scr_step8(st_cur);
  assign ks     = step[7:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
      st_q  <= 7'h7F;
    end else if (fire) begin
      idx_q <= is_last ? '0 : cur_idx + 1'b1;
      if (scr_on) st_q <= step[14:8];
    end
  end
endmodule

// File: rtl/lb1_bip.sv
module lb1_bip (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fire,
  input  logic       first,
  input  logic       last,
  input  logic [7:0] line_byte,
  output logic [7:0] bip,
  output logic       bip_vld
);
  logic [7:0] acc_q, acc_nxt;

  assign acc_nxt = first ? line_byte : (acc_q ^ line_byte);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q   <= '0;
      bip     <= '0;
      bip_vld <= 1'b0;
    end else if (fire) begin
      acc_q <= acc_nxt;
      if (last) begin
        bip     <= acc_nxt;
        bip_vld <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/lb1_stage.sv
module lb1_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  input  logic         in_sof,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic         out_sof
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sof   <= 1'b0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
      out_sof   <= in_sof;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/lb1_err_cnt.sv
module lb1_err_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         add_en,
  input  logic [3:0]   add,
  input  logic         rd,
  output logic [W-1:0] count
);
  logic [W-1:0] base;
  logic [W:0]   sum;

  assign base = rd ? '0 : count;
  assign sum  = {1'b0, base} + (W+1)'(add);

  always_ff @(posedge clk) begin
    if (!rst_n)      count <= '0;
    else if (add_en) count <= sum[W] ? '1 : sum[W-1:0];
    else             count <= base;
  end
endmodule

// File: rtl/line_b1_scr.sv
module line_b1_scr #(
  parameter int ROWS     = 9,
  parameter int COLS     = 90,
  parameter int OH_UNSCR = 3,
  parameter int CNT_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scr_mode,
  input  logic [7:0]       tx_b1_mask,
  input  logic             b1_err_rd,
  output logic [CNT_W-1:0] b1_err_count,
  input  logic             rx_in_valid,
  output logic             rx_in_ready,
  input  logic [7:0]       rx_in_data,
  input  logic             rx_in_sof,
  output logic             rx_out_valid,
  input  logic             rx_out_ready,
  output logic [7:0]       rx_out_data,
  output logic             rx_out_sof,
  input  logic             tx_in_valid,
  output logic             tx_in_ready,
  input  logic [7:0]       tx_in_data,
  input  logic             tx_in_sof,
  output logic             tx_out_valid,
  input  logic             tx_out_ready,
  output logic [7:0]       tx_out_data,
  output logic             tx_out_sof
);
  import lb1_pkg::*;

  // ---------------- receive lane ----------------
  logic       rx_fire, rx_first, rx_last, rx_b1, rx_scr;
  logic [7:0] rx_ks, rx_descr, rx_bip, rx_err_bits;
  logic       rx_bip_vld, rx_add_en;

  assign rx_fire = rx_in_valid && rx_in_ready;

  lb1_frame_scr #(.ROWS(ROWS), .COLS(COLS), .OH_UNSCR(OH_UNSCR)) u_rx_pos (
    .clk(clk), .rst_n(rst_n), .fire(rx_fire), .sof(rx_in_sof),
    .is_first(rx_first), .is_last(rx_last), .is_b1(rx_b1),
    .scr_on(rx_scr), .ks(rx_ks));

  assign rx_descr = (scr_mode && rx_scr) ? (rx_in_data ^ rx_ks) : rx_in_data;

  lb1_bip u_rx_bip (
    .clk(clk), .rst_n(rst_n), .fire(rx_fire), .first(rx_first),
    .last(rx_last), .line_byte(rx_in_data), .bip(rx_bip), .bip_vld(rx_bip_vld));

  assign rx_err_bits = scr_mode ? (rx_descr ^ rx_bip) : rx_in_data;
  assign rx_add_en   = rx_fire && rx_b1 && (!scr_mode || rx_bip_vld);

  lb1_err_cnt #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .add_en(rx_add_en), .add(ones8(rx_err_bits)),
    .rd(b1_err_rd), .count(b1_err_count));

  lb1_stage #(.W(8)) u_rx_stage (
    .clk(clk), .rst_n(rst_n),
    .in_valid(rx_in_valid), .in_ready(rx_in_ready),
    .in_data(rx_descr), .in_sof(rx_in_sof),
    .out_valid(rx_out_valid), .out_ready(rx_out_ready),
    .out_data(rx_out_data), .out_sof(rx_out_sof));

  // ---------------- transmit lane ----------------
  logic       tx_fire, tx_first, tx_last, tx_b1, tx_scr, tx_bip_vld;
  logic [7:0] tx_ks, tx_bip, tx_b1_val, tx_pre, tx_line;

  assign tx_fire = tx_in_valid && tx_in_ready;

  lb1_frame_scr #(.ROWS(ROWS), .COLS(COLS), .OH_UNSCR(OH_UNSCR)) u_tx_pos (
    .clk(clk), .rst_n(rst_n), .fire(tx_fire), .sof(tx_in_sof),
    .is_first(tx_first), .is_last(tx_last), .is_b1(tx_b1),
    .scr_on(tx_scr), .ks(tx_ks));

  assign tx_b1_val = scr_mode ? ((tx_bip_vld ? tx_bip : 8'h00) ^ tx_b1_mask)
                              : tx_b1_mask;
  assign tx_pre    = tx_b1 ? tx_b1_val : tx_in_data;
  assign tx_line   = (scr_mode && tx_scr) ? (tx_pre ^ tx_ks) : tx_pre;

  lb1_bip u_tx_bip (
    .clk(clk), .rst_n(rst_n), .fire(tx_fire), .first(tx_first),
    .last(tx_last), .line_byte(tx_line), .bip(tx_bip), .bip_vld(tx_bip_vld));

  lb1_stage #(.W(8)) u_tx_stage (
    .clk(clk), .rst_n(rst_n),
    .in_valid(tx_in_valid), .in_ready(tx_in_ready),
    .in_data(tx_line), .in_sof(tx_in_sof),
    .out_valid(tx_out_valid), .out_ready(tx_out_ready),
    .out_data(tx_out_data), .out_sof(tx_out_sof));
endmodule

// File: rtl/lb1_chk.sv
module lb1_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scr_mode,
  input logic             b1_err_rd,
  input logic [CNT_W-1:0] b1_err_count,
  input logic             rx_in_valid,
  input logic             rx_in_ready,
  input logic [7:0]       rx_in_data,
  input logic             rx_out_valid,
  input logic             rx_out_ready,
  input logic [7:0]       rx_out_data,
  input logic             rx_out_sof,
  input logic             tx_in_valid,
  input logic             tx_in_ready,
  input logic             tx_out_valid,
  input logic             tx_out_ready,
  input logic [7:0]       tx_out_data,
  input logic             tx_out_sof
);
  // R1
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_out_valid && !rx_out_ready |=> rx_out_valid && $stable(rx_out_data) && $stable(rx_out_sof));
  // R1
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_out_valid && !tx_out_ready |=> tx_out_valid && $stable(tx_out_data) && $stable(tx_out_sof));
  // R1
  rx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_in_valid && rx_in_ready |=> rx_out_valid);
  // R1
  tx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_in_valid && tx_in_ready |=> tx_out_valid);
  // R4
  rx_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !scr_mode && rx_in_valid && rx_in_ready |=> rx_out_data == $past(rx_in_data));
  // R10
  cnt_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !b1_err_rd |=> b1_err_count >= $past(b1_err_count));
  // R6
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !b1_err_rd |=> (b1_err_count - $past(b1_err_count)) <= CNT_W'(8));
  // R7
  cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_in_valid && !b1_err_rd |=> $stable(b1_err_count));
  // R11
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    b1_err_rd |=> b1_err_count <= CNT_W'(8));
endmodule

bind line_b1_scr lb1_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scr_mode(scr_mode), .b1_err_rd(b1_err_rd),
  .b1_err_count(b1_err_count),
  .rx_in_valid(rx_in_valid), .rx_in_ready(rx_in_ready), .rx_in_data(rx_in_data),
  .rx_out_valid(rx_out_valid), .rx_out_ready(rx_out_ready),
  .rx_out_data(rx_out_data), .rx_out_sof(rx_out_sof),
  .tx_in_valid(tx_in_valid), .tx_in_ready(tx_in_ready),
  .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready),
  .tx_out_data(tx_out_data), .tx_out_sof(tx_out_sof));

// File: tb/line_b1_scr_tb.sv
module line_b1_scr_tb;
  localparam int FL   = 810;
  localparam int B1I  = 90;
  localparam int OHU  = 3;
  localparam int CW   = 6;
  localparam int CMAX = (1 << CW) - 1;
  localparam int MAXF = 10;
  localparam int MAXB = MAXF * FL;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n, scr_mode, b1_err_rd;
  logic [7:0]    tx_b1_mask;
  logic [CW-1:0] b1_err_count;
  logic          rx_in_valid, rx_in_ready, rx_in_sof, rx_out_valid, rx_out_ready, rx_out_sof;
  logic [7:0]    rx_in_data, rx_out_data;
  logic          tx_in_valid, tx_in_ready, tx_in_sof, tx_out_valid, tx_out_ready, tx_out_sof;
  logic [7:0]    tx_in_data, tx_out_data;

  line_b1_scr #(.CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .scr_mode(scr_mode), .tx_b1_mask(tx_b1_mask),
    .b1_err_rd(b1_err_rd), .b1_err_count(b1_err_count),
    .rx_in_valid(rx_in_valid), .rx_in_ready(rx_in_ready), .rx_in_data(rx_in_data),
    .rx_in_sof(rx_in_sof), .rx_out_valid(rx_out_valid), .rx_out_ready(rx_out_ready),
    .rx_out_data(rx_out_data), .rx_out_sof(rx_out_sof),
    .tx_in_valid(tx_in_valid), .tx_in_ready(tx_in_ready), .tx_in_data(tx_in_data),
    .tx_in_sof(tx_in_sof), .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready),
    .tx_out_data(tx_out_data), .tx_out_sof(tx_out_sof));

  int n_tests = 0;
  int n_fail  = 0;
  int exp_cnt;
  logic [7:0] ks_tab [0:FL-1];
  logic [7:0] rx_src [0:MAXB-1];
  logic [7:0] rx_exp [0:MAXB-1];
  logic [7:0] tx_src [0:MAXB-1];
  logic [7:0] tx_exp [0:MAXB-1];
  logic [7:0] rx_bip_prev, tx_bip_prev;
  bit         rx_have;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic int popc(input logic [7:0] v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += v[i];
    return n;
  endfunction

  function automatic int sat(input int v);
    return (v > CMAX) ? CMAX : v;
  endfunction

  // keystream from the bit recurrence b[n] = b[n-6] ^ b[n-7], first seven bits one (R3)
  task automatic build_ks();
    bit b [0:(FL-OHU)*8-1];
    for (int n = 0; n < (FL-OHU)*8; n++) b[n] = (n < 7) ? 1'b1 : (b[n-6] ^ b[n-7]);
    for (int i = 0; i < FL; i++) begin
      ks_tab[i] = 8'h00;
      if (i >= OHU)
        for (int j = 0; j < 8; j++) ks_tab[i][7-j] = b[(i-OHU)*8 + j];
    end
  endtask

  task automatic do_reset(input bit mode, input logic [7:0] mask);
    @(negedge clk);
    rst_n = 1'b0; scr_mode = mode; tx_b1_mask = mask; b1_err_rd = 1'b0;
    rx_in_valid = 1'b0; tx_in_valid = 1'b0; rx_out_ready = 1'b0; tx_out_ready = 1'b0;
    rx_in_data = '0; tx_in_data = '0; rx_in_sof = 1'b0; tx_in_sof = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    exp_cnt = 0; rx_have = 1'b0; rx_bip_prev = '0; tx_bip_prev = '0;
  endtask

  function automatic logic [7:0] err_pat(input int f, input bit force_ff);
    logic [7:0] r = 8'($urandom);
    if (force_ff) return 8'hFF;
    case (f % 4)
      0: return 8'h00;
      1: return 8'h01 << ($urandom % 8);
      2: return r;
      default: return 8'hFF;
    endcase
  endfunction

  // expected streams and counter (R2 R3 R4 R5 R6 R7 R8 R9 R10 R11)
  task automatic build(input int nfr, input bit mode, input bit force_ff, input int rd_frame);
    logic [7:0] rx_acc, tx_acc, line, pre, e, o;
    int c;
    for (int f = 0; f < nfr; f++) begin
      rx_acc = '0; tx_acc = '0; c = 0;
      for (int i = 0; i < FL; i++) begin
        int k = f*FL + i;
        line = 8'($urandom);
        if (i == B1I) begin
          e = err_pat(f, force_ff);
          if (mode) begin
            if (rx_have) begin
              line = rx_bip_prev ^ e ^ ks_tab[i];
              c = popc(e);
            end
          end else begin
            line = e;
            c = popc(e);
          end
        end
        rx_src[k] = line;
        rx_exp[k] = (mode && i >= OHU) ? (line ^ ks_tab[i]) : line;
        rx_acc ^= line;
        tx_src[k] = 8'($urandom);
        if (i == B1I) pre = mode ? (tx_bip_prev ^ tx_b1_mask) : tx_b1_mask;
        else          pre = tx_src[k];
        o = (mode && i >= OHU) ? (pre ^ ks_tab[i]) : pre;
        tx_exp[k] = o;
        tx_acc ^= o;
      end
      rx_bip_prev = rx_acc; rx_have = 1'b1; tx_bip_prev = tx_acc;
      exp_cnt = (f == rd_frame) ? sat(c) : sat(exp_cnt + c);
    end
  endtask

  task automatic run(input int n, input int rd_k);
    int ri = 0, ti = 0, ro = 0, to = 0;
    while (ro < n || to < n) begin
      @(negedge clk);
      b1_err_rd    = 1'b0;
      rx_in_valid  = (ri < n) && ($urandom % 4 != 0);
      rx_in_data   = rx_src[(ri < n) ? ri : 0];
      rx_in_sof    = (ri % FL) == 0;
      tx_in_valid  = (ti < n) && ($urandom % 4 != 0);
      tx_in_data   = tx_src[(ti < n) ? ti : 0];
      tx_in_sof    = (ti % FL) == 0;
      rx_out_ready = ($urandom % 4 != 0);
      tx_out_ready = ($urandom % 4 != 0);
      #1;
      if (rx_in_valid && rx_in_ready) begin
        if (ri == rd_k) b1_err_rd = 1'b1;
        ri++;
      end
      if (tx_in_valid && tx_in_ready) ti++;
      if (rx_out_valid && rx_out_ready) begin
        check(rx_out_data == rx_exp[ro], scr_mode ? "R3" : "R4", "rx byte",
              int'(rx_out_data), int'(rx_exp[ro]));
        check(rx_out_sof == ((ro % FL) == 0), "R1 R2", "rx sof", int'(rx_out_sof), int'((ro % FL) == 0));
        ro++;
      end
      if (tx_out_valid && tx_out_ready) begin
        string tg;
        if ((to % FL) == B1I) tg = scr_mode ? "R5 R8" : "R9";
        else                  tg = scr_mode ? "R3" : "R4";
        check(tx_out_data == tx_exp[to], tg, "tx byte", int'(tx_out_data), int'(tx_exp[to]));
        check(tx_out_sof == ((to % FL) == 0), "R1 R2", "tx sof", int'(tx_out_sof), int'((to % FL) == 0));
        to++;
      end
    end
    @(negedge clk);
    rx_in_valid = 1'b0; tx_in_valid = 1'b0; b1_err_rd = 1'b0;
  endtask

  task automatic check_count(input string req);
    @(negedge clk); #1;
    check(int'(b1_err_count) == exp_cnt, req, "error count", int'(b1_err_count), exp_cnt);
    b1_err_rd = 1'b1;
    @(negedge clk);
    b1_err_rd = 1'b0; #1;
    check(b1_err_count == '0, "R11", "count after read", int'(b1_err_count), 0);
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_B1B1));
    build_ks();
    check(ks_tab[OHU] == 8'hFE, "R3", "first keystream byte", int'(ks_tab[OHU]), 8'hFE);

    // R12 reset state
    do_reset(1'b1, 8'h00);
    #1;
    check(b1_err_count == '0, "R12", "count", int'(b1_err_count), 0);
    check(!rx_out_valid && !tx_out_valid, "R12", "out valids", int'({rx_out_valid, tx_out_valid}), 0);
    check(rx_in_ready && tx_in_ready, "R12", "in readies", int'({rx_in_ready, tx_in_ready}), 3);

    // scrambled mode, zero mask; first frame B1 uncounted (R6)
    build(4, 1'b1, 1'b0, -1);
    run(4*FL, -1);
    check_count("R6");

    // scrambled mode, nonzero mask (R8)
    do_reset(1'b1, 8'h5A);
    build(3, 1'b1, 1'b0, -1);
    run(3*FL, -1);
    check_count("R6");

    // transparent mode (R4 R7 R9)
    do_reset(1'b0, 8'hC3);
    build(4, 1'b0, 1'b0, -1);
    run(4*FL, -1);
    check_count("R7");

    // saturation: 9 frames of 8 errors each exceed 2^CW-1 (R10)
    do_reset(1'b0, 8'h3C);
    build(9, 1'b0, 1'b1, -1);
    run(9*FL, -1);
    check_count("R10");

    // read strobe coinciding with an incoming B1 byte (R11)
    do_reset(1'b0, 8'h81);
    build(4, 1'b0, 1'b1, 2);
    run(4*FL, 2*FL + B1I);
    check_count("R11");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule